// File: doc/BRIEF.md
# Hysteretic Threshold Gate

This block is a state-holding M-of-N threshold gate for dual-rail, null-separated datapaths. It counts how many of its N single-rail inputs are high. Once that count reaches the threshold M, the output goes high. The output then stays high until every input has returned low. This hysteresis keeps the output steady while a data wavefront or a null wavefront is only partly through. With M equal to N the gate acts as a completion element in the manner of a C-element. With M equal to 1 it acts as an OR gate that holds its value until the inputs are all low.

The model is clocked so that it fits a synchronous flow. The inputs are sampled on each rising clock edge, and the stored output is updated at the same edge. It follows the set and clear conditions of the threshold gate one edge after they appear. Designers place one instance per completion or threshold node and size it with two parameters.

Top module: `hyst_thresh_gate`

## Requirements
- R1: While `rst` is high at a rising edge, `out_q` is 0 after that edge, whatever `in_vec` holds.
- R2: When at least M bits of `in_vec` are 1 at a rising edge (and `rst` is low), `out_q` is 1 after that edge.
- R3: When `out_q` is 0 and fewer than M bits of `in_vec` are 1 at an edge, `out_q` stays 0.
- R4: When `out_q` is 1 and at least one bit of `in_vec` is 1 at an edge, `out_q` stays 1, even if the count is below M.
- R5: When all bits of `in_vec` are 0 at an edge, `out_q` is 0 after that edge.
- R6: With M equal to N, the gate rises only when all inputs are 1 and falls only when all are 0.
- R7: `out_q` rises only after an edge with at least M ones, and falls only after an edge with all inputs low or with reset. While the inputs only gain ones from all-low, the output never goes up and then back down.
- R8: The threshold must satisfy 1 <= M <= N, and elaboration stops with an error otherwise. Both ends of that range are legal, and with M = 1 a single high input sets the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the stored output |
| in_vec | input | N_IN | Single-rail inputs that are counted against the threshold |
| out_q | output | 1 | Registered, hysteretic gate output |

## Verification
The properties assume that `in_vec` is fully defined and stable around each rising edge, with one new pattern per cycle. They also assume that `rst` is driven low or high and never left unknown. The stimulus changes the inputs and the reset only on the falling edge, so every pattern is held for a full cycle before it is sampled. The bench runs every one of the sixteen input patterns from both a cleared and a set state, and also walks a wavefront-shaped table. This includes jumps that move the count straight between zero and the threshold. Under those conditions the properties hold.

// File: rtl/tg_pkg.sv
package tg_pkg;
  // width needed to hold a count of 0..n
  function automatic int cnt_w(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/tg_popcount.sv
module tg_popcount #(
  parameter int N_IN  = 4,
  parameter int CNT_W = 3
) (
  input  logic [N_IN-1:0]  bits_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] part [0:N_IN];

  assign part[0] = '0;
  for (genvar g = 0; g < N_IN; g++) begin : g_acc
    assign part[g+1] = part[g] + CNT_W'(bits_i[g]);
  end

  assign count_o = part[N_IN];
endmodule

// File: rtl/tg_cond.sv
module tg_cond #(
  parameter int N_IN  = 4,
  parameter int M_THR = 3,
  parameter int CNT_W = 3
) (
  input  logic [CNT_W-1:0] count_i,
  output logic             set_o,
  output logic             clr_o
);
  assign set_o = (count_i >= CNT_W'(M_THR));
  assign clr_o = (count_i == '0);

  // R7: set and clear can never be requested together while M >= 1
  always_comb begin
    a_r7_excl: assert (!(set_o && clr_o))
      else $error("set and clear both active");
  end
endmodule

// File: rtl/tg_state.sv
module tg_state (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/hyst_thresh_gate.sv
module hyst_thresh_gate #(
  parameter int N_IN  = 4,
  parameter int M_THR = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] in_vec,
  output logic            out_q
);
  localparam int CNT_W = tg_pkg::cnt_w(N_IN);

  // R8: threshold range check at elaboration
  if (M_THR < 1 || M_THR > N_IN) begin : g_bad_thr
    $error("hyst_thresh_gate: M_THR must lie in 1..N_IN");
  end

  logic [CNT_W-1:0] count;
  logic             set_c;
  logic             clr_c;

  tg_popcount #(.N_IN(N_IN), .CNT_W(CNT_W)) u_pop (
    .bits_i (in_vec),
    .count_o(count)
  );

  tg_cond #(.N_IN(N_IN), .M_THR(M_THR), .CNT_W(CNT_W)) u_cond (
    .count_i(count),
    .set_o  (set_c),
    .clr_o  (clr_c)
  );

  tg_state u_state (
    .clk  (clk),
    .rst  (rst),
    .set_i(set_c),
    .clr_i(clr_c),
    .q_o  (out_q)
  );

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> !out_q);

  a_r2_rise_at_thr: assert property (@(posedge clk) disable iff (rst)
    ($countones(in_vec) >= M_THR) |=> out_q);

  a_r3_stay_low: assert property (@(posedge clk) disable iff (rst)
    (!out_q && ($countones(in_vec) < M_THR)) |=> !out_q);

  a_r4_hold_high: assert property (@(posedge clk) disable iff (rst)
    (out_q && (in_vec != '0)) |=> out_q);

  a_r5_clear_on_null: assert property (@(posedge clk) disable iff (rst)
    (in_vec == '0) |=> !out_q);

  a_r7_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(out_q) |-> ($countones($past(in_vec)) >= M_THR));

  a_r7_fall_cause: assert property (@(posedge clk)
    $fell(out_q) |-> ($past(in_vec) == '0 || $past(rst)));
endmodule

// File: tb/hyst_thresh_gate_bench.sv
`timescale 1ns/1ps
module hyst_thresh_gate_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] in_vec = 4'h0;
  logic       out_a, out_b, out_c;
  int         n_chk = 0;
  int         n_bad = 0;
  logic       ref_a, ref_b, ref_c;
  bit         done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  // A: 3-of-4, B: 4-of-4 (C-element), C: 1-of-4
  hyst_thresh_gate #(.N_IN(4), .M_THR(3)) u_hyst_thresh_gate (
    .clk(clk), .rst(rst), .in_vec(in_vec), .out_q(out_a));
  hyst_thresh_gate #(.N_IN(4), .M_THR(4)) u_gate_c_elem (
    .clk(clk), .rst(rst), .in_vec(in_vec), .out_q(out_b));
  hyst_thresh_gate #(.N_IN(4), .M_THR(1)) u_gate_or_hold (
    .clk(clk), .rst(rst), .in_vec(in_vec), .out_q(out_c));

  // table entry: [4:1] input pattern, [0] expected 3-of-4 output
  localparam logic [4:0] VEC [16] = '{
    {4'b0001, 1'b0}, {4'b0011, 1'b0}, {4'b0111, 1'b1}, {4'b0011, 1'b1},
    {4'b0001, 1'b1}, {4'b0000, 1'b0}, {4'b1000, 1'b0}, {4'b1100, 1'b0},
    {4'b0110, 1'b0}, {4'b1110, 1'b1}, {4'b1111, 1'b1}, {4'b1000, 1'b1},
    {4'b0000, 1'b0}, {4'b1011, 1'b1}, {4'b0000, 1'b0}, {4'b0101, 1'b0}
  };

  function automatic logic ref_nx(input logic q, input logic [3:0] v, input int m);
    int c;
    c = $countones(v);
    if (c >= m) return 1'b1;
    if (c == 0) return 1'b0;
    return q;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s in=%b actual=%b expected=%b", req, in_vec, act, exp);
    end
  endtask

  // drive on falling edge, result visible at next falling edge
  task automatic step(input logic [3:0] v);
    in_vec = v;
    rst    = 1'b0;
    @(negedge clk);
    ref_a = ref_nx(ref_a, v, 3);
    ref_b = ref_nx(ref_b, v, 4);
    ref_c = ref_nx(ref_c, v, 1);
  endtask

  task automatic do_reset(input logic [3:0] v);
    in_vec = v;
    rst    = 1'b1;
    @(negedge clk);
    ref_a = 1'b0; ref_b = 1'b0; ref_c = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4ns * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset(4'b1111);
    chk("R1 reset with all inputs high", out_a, 1'b0);
    chk("R1 reset c-element", out_b, 1'b0);
    chk("R1 reset 1-of-4", out_c, 1'b0);

    // R2 R3 R4 R5 R7: wavefront table on the 3-of-4 gate
    for (int i = 0; i < 16; i++) begin
      step(VEC[i][4:1]);
      chk("R2/R3/R4/R5 table", out_a, VEC[i][0]);
    end

    // R6: C-element corner cases
    do_reset(4'b0000);
    step(4'b0111); chk("R6 c-elem 3 of 4 stays low", out_b, 1'b0);
    step(4'b1111); chk("R6 c-elem all high rises", out_b, 1'b1);
    step(4'b0001); chk("R6 c-elem holds with one high", out_b, 1'b1);
    step(4'b0000); chk("R6 c-elem all low falls", out_b, 1'b0);

    // R8: lower end M=1 is legal, single input sets
    step(4'b0100); chk("R8 M=1 single input sets", out_c, 1'b1);
    step(4'b0010); chk("R8 M=1 holds", out_c, 1'b1);
    step(4'b0000); chk("R8 M=1 clears", out_c, 1'b0);

    // R1: reset wins over a set condition while high, then release below threshold
    step(4'b1111); chk("R2 set before reset", out_a, 1'b1);
    do_reset(4'b1111); chk("R1 reset while high", out_a, 1'b0);
    step(4'b0011); chk("R3 after reset below threshold", out_a, 1'b0);

    // R7: monotone rising wavefront, one bit at a time
    do_reset(4'b0000);
    step(4'b0001); chk("R7 monotone 1", out_a, 1'b0);
    step(4'b0011); chk("R7 monotone 2", out_a, 1'b0);
    step(4'b0111); chk("R7 monotone 3", out_a, 1'b1);
    step(4'b1111); chk("R7 monotone 4", out_a, 1'b1);

    // exhaustive: every pattern from a cleared and a set state, all gates
    for (int s = 0; s < 2; s++) begin
      for (int v = 0; v < 16; v++) begin
        do_reset(4'b0000);
        if (s == 1) step(4'b1111);
        step(4'(v));
        chk("R2/R3/R4/R5 sweep 3-of-4", out_a, ref_a);
        chk("R6 sweep c-element", out_b, ref_b);
        chk("R8 sweep 1-of-4", out_c, ref_c);
      end
    end

    finish_run();
  end
endmodule